// File: doc/BRIEF.md
# Framebuffer Control Register File

This block holds the programmable state of an 8-bit indexed-colour framebuffer controller. A host reaches it over a 32-bit, word-only register bus, where address ranges select a 256-entry colour lookup table, a 3-entry cursor colour table, a 512-word cursor bitmap and three single registers. The single registers are a display control word, a screen start offset and a cursor position. A pixel pipeline reads the same state through its own combinational read ports, so a lookup never waits on host traffic.

The block also drives a frame interrupt. A one-cycle frame-done pulse from the timing side raises it. The host acknowledges it by performing any register write. Writes to the video timing registers are accepted and discarded.

The bus request is qualified by `cmd_valid` and is taken in the cycle it is presented. There is no back-pressure, so the block has no ready output. A read answers exactly one cycle later with `rsp_valid` high for one cycle, and the host must be able to accept that response.

Top module: `fbctl_regs`

## Requirements
- R1: While reset is asserted, and after it is released, the interrupt is low. Both colour tables, the cursor bitmap, the control word, the screen start offset and the cursor position all read as zero.
- R2: A write to byte offset 0x800 to 0xFFF stores colour entry (offset - 0x800) >> 3. The data bits map as red = 23:16, green = 15:8 and blue = 7:0. `pix_pal_rgb` returns the entry as {red, green, blue}, and a bus read returns it zero-extended.
- R3: A write to byte offset 0x508 to 0x51F stores cursor colour entry (offset - 0x508) >> 3 (entries 0 to 2), using the packing of R2. Bus reads return that packing, and `pix_cur_rgb` returns zero for index 3.
- R4: A write to byte offset 0x1000 to 0x1FFF stores data bits 15:0 in bitmap word (offset - 0x1000) >> 3. The word is readable on the bus and on `pix_pat_word`.
- R5: The control word lives at offset 0x300. Its bit 10 drives `blank`, and its bit 23 drives `cursor_off`. Its bits 22:20, taken as codes 0 to 7, give `depth_bpp` = 1, 2, 4, 8, 15, 16, 0, 0.
- R6: Offset 0x400 holds the 32-bit screen start offset. Offset 0x638 holds the cursor position from data bits 23:0, with `cursor_x` taken from bits 23:12 and `cursor_y` from bits 11:0.
- R7: A write to a timing register (0x000, 0x108 to 0x170, 0x200) or to any other unlisted offset changes no stored state.
- R8: A read of any offset not named in R2 to R6 returns zero.
- R9: The cycle after a frame-done pulse, `frame_irq` is high. The cycle after a write with no frame-done, it is low. A read or an idle cycle leaves it unchanged, and frame-done wins over a write in the same cycle.
- R10: `rsp_valid` is high in exactly the cycle after a read request, and it carries the value held before that cycle's edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Bus request present |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 16 | Byte offset of the word |
| cmd_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 32 | Read data |
| pix_pal_idx | input | 8 | Colour table lookup index |
| pix_pal_rgb | output | 24 | Colour entry {r,g,b} |
| pix_cur_idx | input | 2 | Cursor colour lookup index |
| pix_cur_rgb | output | 24 | Cursor colour {r,g,b} |
| pix_pat_idx | input | 9 | Cursor bitmap word index |
| pix_pat_word | output | 16 | Cursor bitmap word |
| blank | output | 1 | Force display blank |
| cursor_off | output | 1 | Cursor disabled |
| depth_bpp | output | 5 | Decoded bits per pixel |
| top_offset | output | 32 | Screen start offset |
| cursor_x | output | 12 | Cursor column |
| cursor_y | output | 12 | Cursor row |
| frame_done | input | 1 | End-of-frame pulse |
| frame_irq | output | 1 | Frame interrupt |

## Verification
The embedded properties assume that `cmd_valid`, `cmd_write` and `frame_done` are never unknown once reset is released, and that at most one bus request arrives per cycle. No request may be issued during reset. The bench drives every input at the falling edge from a single task, keeps requests idle while reset is low, and leaves each pixel index at a defined value. It mixes directed offsets at each range edge and alias with random indices, and it drives frame-done pulses that land alone, together with writes, and together with reads.

// File: rtl/fbctl_pkg.sv
`timescale 1ns/1ps
package fbctl_pkg;
  localparam int PAL_LO    = 'h0800;
  localparam int PAL_HI    = 'h1000;
  localparam int CPAL_LO   = 'h0508;
  localparam int CPAL_HI   = 'h0520;
  localparam int PAT_LO    = 'h1000;
  localparam int PAT_HI    = 'h2000;
  localparam int CTRL_OFS  = 'h0300;
  localparam int TOP_OFS   = 'h0400;
  localparam int POS_OFS   = 'h0638;
  localparam int BLANK_BIT = 10;
  localparam int NOCUR_BIT = 23;
  localparam int DEPTH_LSB = 20;

  typedef enum logic [2:0] {
    RG_NONE, RG_PAL, RG_CPAL, RG_PAT, RG_CTRL, RG_TOP, RG_POS
  } region_e;

  function automatic logic [4:0] depth_of(input logic [2:0] code);
    case (code)
      3'd0: return 5'd1;
      3'd1: return 5'd2;
      3'd2: return 5'd4;
      3'd3: return 5'd8;
      3'd4: return 5'd15;
      3'd5: return 5'd16;
      default: return 5'd0;
    endcase
  endfunction
endpackage

// File: rtl/fbctl_decode.sv
`timescale 1ns/1ps
module fbctl_decode
  import fbctl_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int PAL_IW  = 8,
  parameter int CPAL_IW = 2,
  parameter int PAT_IW  = 9
) (
  input  logic [ADDR_W-1:0]  addr,
  output region_e            region,
  output logic [PAL_IW-1:0]  pal_idx,
  output logic [CPAL_IW-1:0] cpal_idx,
  output logic [PAT_IW-1:0]  pat_idx
);
  logic [ADDR_W-1:0] cpal_ofs;
  logic [ADDR_W-1:0] pal_ofs;
  logic [ADDR_W-1:0] pat_ofs;
  logic [5:0] hits;

  always_comb begin
    hits[0] = (addr >= ADDR_W'(PAL_LO))  && (addr < ADDR_W'(PAL_HI));
    hits[1] = (addr >= ADDR_W'(CPAL_LO)) && (addr < ADDR_W'(CPAL_HI));
    hits[2] = (addr >= ADDR_W'(PAT_LO))  && (addr < ADDR_W'(PAT_HI));
    hits[3] = (addr == ADDR_W'(CTRL_OFS));
    hits[4] = (addr == ADDR_W'(TOP_OFS));
    hits[5] = (addr == ADDR_W'(POS_OFS));
  end

  always_comb begin
    region = RG_NONE;
    if (hits[0])      region = RG_PAL;
    else if (hits[1]) region = RG_CPAL;
    else if (hits[2]) region = RG_PAT;
    else if (hits[3]) region = RG_CTRL;
    else if (hits[4]) region = RG_TOP;
    else if (hits[5]) region = RG_POS;
  end

  assign pal_ofs  = addr - ADDR_W'(PAL_LO);
  assign cpal_ofs = addr - ADDR_W'(CPAL_LO);
  assign pat_ofs  = addr - ADDR_W'(PAT_LO);
  assign pal_idx  = pal_ofs[PAL_IW+2:3];
  assign cpal_idx = cpal_ofs[CPAL_IW+2:3];
  assign pat_idx  = pat_ofs[PAT_IW+2:3];

  // ranges must never overlap (R7, R8)
  always_comb begin
    assert_decode_exclusive_R8: assert ($onehot0(hits));
  end
endmodule

// File: rtl/fbctl_regarray.sv
`timescale 1ns/1ps
module fbctl_regarray #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 24,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [IW-1:0]    pix_addr,
  output logic [WIDTH-1:0] pix_data,
  input  logic [IW-1:0]    bus_addr,
  output logic [WIDTH-1:0] bus_data
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic wr_ok;

  assign wr_ok = we && (int'(waddr) < DEPTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_ok) begin
      mem[waddr] <= wdata;
    end
  end

  assign pix_data = (int'(pix_addr) < DEPTH) ? mem[pix_addr] : '0;
  assign bus_data = (int'(bus_addr) < DEPTH) ? mem[bus_addr] : '0;

  // a write lands in its entry (R2, R3, R4)
  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> mem[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/fbctl_irq.sv
`timescale 1ns/1ps
module fbctl_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_evt,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq <= 1'b0;
    else if (set_evt) irq <= 1'b1;
    else if (clr_evt) irq <= 1'b0;
  end

  assert_irq_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> irq);
  assert_irq_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && !set_evt) |=> !irq);
  assert_irq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_evt && !set_evt) |=> $stable(irq));
endmodule

// File: rtl/fbctl_regs.sv
`timescale 1ns/1ps
module fbctl_regs
  import fbctl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAL_N  = 256,
  parameter int CPAL_N = 3,
  parameter int PAT_N  = 512,
  parameter int PAT_W  = 16,
  parameter int POS_W  = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  input  logic                     cmd_write,
  input  logic [ADDR_W-1:0]        cmd_addr,
  input  logic [31:0]              cmd_wdata,
  output logic                     rsp_valid,
  output logic [31:0]              rsp_data,
  input  logic [$clog2(PAL_N)-1:0] pix_pal_idx,
  output logic [23:0]              pix_pal_rgb,
  input  logic [$clog2(CPAL_N)-1:0] pix_cur_idx,
  output logic [23:0]              pix_cur_rgb,
  input  logic [$clog2(PAT_N)-1:0] pix_pat_idx,
  output logic [PAT_W-1:0]         pix_pat_word,
  output logic                     blank,
  output logic                     cursor_off,
  output logic [4:0]               depth_bpp,
  output logic [31:0]              top_offset,
  output logic [POS_W-1:0]         cursor_x,
  output logic [POS_W-1:0]         cursor_y,
  input  logic                     frame_done,
  output logic                     frame_irq
);
  localparam int PAL_IW  = $clog2(PAL_N);
  localparam int CPAL_IW = $clog2(CPAL_N);
  localparam int PAT_IW  = $clog2(PAT_N);
  localparam int POS_BITS = 2 * POS_W;

  region_e             region;
  logic [PAL_IW-1:0]   pal_idx;
  logic [CPAL_IW-1:0]  cpal_idx;
  logic [PAT_IW-1:0]   pat_idx;
  logic                wr, rd;
  logic [23:0]         pal_bus, cpal_bus;
  logic [PAT_W-1:0]    pat_bus;
  logic [31:0]         ctrl_q, top_q;
  logic [POS_BITS-1:0] pos_q;
  logic [31:0]         rd_mux;

  assign wr = cmd_valid && cmd_write;
  assign rd = cmd_valid && !cmd_write;

  fbctl_decode #(.ADDR_W(ADDR_W), .PAL_IW(PAL_IW), .CPAL_IW(CPAL_IW), .PAT_IW(PAT_IW))
  u_dec (.addr(cmd_addr), .region(region), .pal_idx(pal_idx),
         .cpal_idx(cpal_idx), .pat_idx(pat_idx));

  fbctl_regarray #(.DEPTH(PAL_N), .WIDTH(24), .IW(PAL_IW)) u_pal (
    .clk(clk), .rst_n(rst_n), .we(wr && region == RG_PAL), .waddr(pal_idx),
    .wdata(cmd_wdata[23:0]), .pix_addr(pix_pal_idx), .pix_data(pix_pal_rgb),
    .bus_addr(pal_idx), .bus_data(pal_bus));

  fbctl_regarray #(.DEPTH(CPAL_N), .WIDTH(24), .IW(CPAL_IW)) u_cpal (
    .clk(clk), .rst_n(rst_n), .we(wr && region == RG_CPAL), .waddr(cpal_idx),
    .wdata(cmd_wdata[23:0]), .pix_addr(pix_cur_idx), .pix_data(pix_cur_rgb),
    .bus_addr(cpal_idx), .bus_data(cpal_bus));

  fbctl_regarray #(.DEPTH(PAT_N), .WIDTH(PAT_W), .IW(PAT_IW)) u_pat (
    .clk(clk), .rst_n(rst_n), .we(wr && region == RG_PAT), .waddr(pat_idx),
    .wdata(cmd_wdata[PAT_W-1:0]), .pix_addr(pix_pat_idx), .pix_data(pix_pat_word),
    .bus_addr(pat_idx), .bus_data(pat_bus));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      top_q  <= '0;
      pos_q  <= '0;
    end else if (wr) begin
      case (region)
        RG_CTRL: ctrl_q <= cmd_wdata;
        RG_TOP:  top_q  <= cmd_wdata;
        RG_POS:  pos_q  <= cmd_wdata[POS_BITS-1:0];
        default: ;
      endcase
    end
  end

  assign blank      = ctrl_q[BLANK_BIT];
  assign cursor_off = ctrl_q[NOCUR_BIT];
  assign depth_bpp  = depth_of(ctrl_q[DEPTH_LSB+2:DEPTH_LSB]);
  assign top_offset = top_q;
  assign cursor_x   = pos_q[POS_BITS-1:POS_W];
  assign cursor_y   = pos_q[POS_W-1:0];

  always_comb begin
    rd_mux = '0;
    case (region)
      RG_PAL:  rd_mux = {8'h00, pal_bus};
      RG_CPAL: rd_mux = {8'h00, cpal_bus};
      RG_PAT:  rd_mux = 32'(pat_bus);
      RG_CTRL: rd_mux = ctrl_q;
      RG_TOP:  rd_mux = top_q;
      RG_POS:  rd_mux = 32'(pos_q);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd;
      if (rd) rsp_data <= rd_mux;
    end
  end

  fbctl_irq u_irq (.clk(clk), .rst_n(rst_n), .set_evt(frame_done),
                   .clr_evt(wr), .irq(frame_irq));

  assert_rsp_follows_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rsp_valid);
  assert_no_spurious_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !rsp_valid);
  assert_unmapped_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && region == RG_NONE) |=> rsp_data == '0);
  assert_ignored_write_keeps_ctrl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && region == RG_NONE) |=> ($stable(ctrl_q) && $stable(top_q) && $stable(pos_q)));
endmodule

// File: tb/fbctl_regs_test.sv
`timescale 1ns/1ps
module fbctl_regs_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cmd_valid = 0, cmd_write = 0;
  logic [15:0] cmd_addr = 0;
  logic [31:0] cmd_wdata = 0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic [7:0]  pix_pal_idx = 0;
  logic [23:0] pix_pal_rgb;
  logic [1:0]  pix_cur_idx = 0;
  logic [23:0] pix_cur_rgb;
  logic [8:0]  pix_pat_idx = 0;
  logic [15:0] pix_pat_word;
  logic        blank, cursor_off;
  logic [4:0]  depth_bpp;
  logic [31:0] top_offset;
  logic [11:0] cursor_x, cursor_y;
  logic        frame_done = 0;
  logic        frame_irq;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fbctl_regs uut (.*);

  // reference model state
  logic [23:0] mpal [256];
  logic [23:0] mcp  [3];
  logic [15:0] mpat [512];
  logic [31:0] mctrl, mtop;
  logic [23:0] mpos;
  bit          mirq, mrv;
  logic [31:0] mrd;
  string       rd_tag;
  int          bpp_tbl [8] = '{1, 2, 4, 8, 15, 16, 0, 0};

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(int a);
    if (a >= 'h800 && a < 'h1000) return {8'h0, mpal[(a - 'h800) >> 3]};
    if (a >= 'h508 && a < 'h520)  return {8'h0, mcp[(a - 'h508) >> 3]};
    if (a >= 'h1000 && a < 'h2000) return {16'h0, mpat[(a - 'h1000) >> 3]};
    if (a == 'h300) return mctrl;
    if (a == 'h400) return mtop;
    if (a == 'h638) return {8'h0, mpos};
    return 32'h0;
  endfunction

  function automatic string tag_of(int a);
    if (a >= 'h800 && a < 'h1000) return "R2";
    if (a >= 'h508 && a < 'h520)  return "R3";
    if (a >= 'h1000 && a < 'h2000) return "R4";
    if (a == 'h300) return "R5";
    if (a == 'h400 || a == 'h638) return "R6";
    return "R8";
  endfunction

  task automatic compare_all();
    logic [23:0] ecur;
    ecur = (pix_cur_idx < 3) ? mcp[pix_cur_idx] : 24'h0;
    chk(pix_pal_rgb == mpal[pix_pal_idx], "R2 pix_pal_rgb", 32'(pix_pal_rgb), 32'(mpal[pix_pal_idx]));
    chk(pix_cur_rgb == ecur, "R3 pix_cur_rgb", 32'(pix_cur_rgb), 32'(ecur));
    chk(pix_pat_word == mpat[pix_pat_idx], "R4 pix_pat_word", 32'(pix_pat_word), 32'(mpat[pix_pat_idx]));
    chk(blank == mctrl[10], "R5 blank", 32'(blank), 32'(mctrl[10]));
    chk(cursor_off == mctrl[23], "R5 cursor_off", 32'(cursor_off), 32'(mctrl[23]));
    chk(int'(depth_bpp) == bpp_tbl[mctrl[22:20]], "R5 depth_bpp", 32'(depth_bpp), 32'(bpp_tbl[mctrl[22:20]]));
    chk(top_offset == mtop, "R6 top_offset", top_offset, mtop);
    chk(cursor_x == mpos[23:12], "R6 cursor_x", 32'(cursor_x), 32'(mpos[23:12]));
    chk(cursor_y == mpos[11:0], "R6 cursor_y", 32'(cursor_y), 32'(mpos[11:0]));
    chk(frame_irq == mirq, "R9 frame_irq", 32'(frame_irq), 32'(mirq));
    chk(rsp_valid == mrv, "R10 rsp_valid", 32'(rsp_valid), 32'(mrv));
    if (mrv) chk(rsp_data == mrd, rd_tag, rsp_data, mrd);
  endtask

  // one bus cycle: drive at the falling edge, update model at the rising edge
  task automatic cyc(bit v, bit w, int a, logic [31:0] d, bit fd);
    cmd_valid = v; cmd_write = w; cmd_addr = 16'(a); cmd_wdata = d; frame_done = fd;
    @(posedge clk);
    mrv = v && !w;
    if (v && !w) begin
      mrd = model_read(a);
      rd_tag = tag_of(a);
    end
    if (v && w) begin
      if (a >= 'h800 && a < 'h1000) mpal[(a - 'h800) >> 3] = d[23:0];
      else if (a >= 'h508 && a < 'h520) mcp[(a - 'h508) >> 3] = d[23:0];
      else if (a >= 'h1000 && a < 'h2000) mpat[(a - 'h1000) >> 3] = d[15:0];
      else if (a == 'h300) mctrl = d;
      else if (a == 'h400) mtop = d;
      else if (a == 'h638) mpos = d[23:0];
    end
    if (fd) mirq = 1;
    else if (v && w) mirq = 0;
    @(negedge clk);
    cmd_valid = 0; frame_done = 0;
    compare_all();
  endtask

  task automatic wr32(int a, logic [31:0] d); cyc(1, 1, a, d, 0); endtask
  task automatic rd32(int a); cyc(1, 0, a, 32'h0, 0); endtask
  task automatic idle(); cyc(0, 0, 0, 32'h0, 0); endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0h expected %0h", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] snap_ctrl, snap_top;
    logic [11:0] snap_x;
    for (int i = 0; i < 256; i++) mpal[i] = 0;
    for (int i = 0; i < 512; i++) mpat[i] = 0;
    for (int i = 0; i < 3; i++) mcp[i] = 0;
    mctrl = 0; mtop = 0; mpos = 0; mirq = 0; mrv = 0; mrd = 0; rd_tag = "R8";
    repeat (3) @(negedge clk);
    // R1: state during reset
    chk(frame_irq == 0, "R1 irq in reset", 32'(frame_irq), 0);
    chk(rsp_valid == 0, "R1 rsp_valid in reset", 32'(rsp_valid), 0);
    rst_n = 1;
    @(negedge clk);
    chk(top_offset == 0, "R1 top_offset", top_offset, 0);
    chk({cursor_x, cursor_y} == 0, "R1 cursor position", 32'({cursor_x, cursor_y}), 0);
    chk(pix_pal_rgb == 0 && pix_pat_word == 0 && pix_cur_rgb == 0, "R1 tables clear",
        32'(pix_pal_rgb), 0);
    chk(depth_bpp == 5'd1 && !blank && !cursor_off, "R1 control clear", 32'(depth_bpp), 1);
    compare_all();

    // R2: colour table, edges and alias
    wr32('h800, 32'hAB123456);
    wr32('hFF8, 32'h00FEDCBA);
    wr32('hFFC, 32'h00A1B2C3);
    wr32('h7FC, 32'h00777777);
    wr32('h804, 32'h00010203);
    for (int i = 0; i < 24; i++) wr32('h800 + 8 * $urandom_range(0, 255), $urandom);
    rd32('h800); rd32('hFF8); rd32('h7F8);
    for (int i = 0; i < 256; i++) begin pix_pal_idx = 8'(i); idle(); end

    // R3: cursor colours, edges, alias and neighbours
    wr32('h508, 32'h00112233);
    wr32('h510, 32'hFF445566);
    wr32('h518, 32'h00778899);
    wr32('h51C, 32'h00ABCDEF);
    wr32('h520, 32'h00EEEEEE);
    wr32('h500, 32'h00DDDDDD);
    rd32('h508); rd32('h510); rd32('h518); rd32('h520);
    for (int i = 0; i < 4; i++) begin pix_cur_idx = 2'(i); idle(); end

    // R4: cursor bitmap
    wr32('h1000, 32'hDEADBEEF);
    wr32('h1FF8, 32'h0000C3A5);
    wr32('h1FFC, 32'h00005A5A);
    for (int i = 0; i < 40; i++) wr32('h1000 + 8 * $urandom_range(0, 511), $urandom);
    rd32('h1000); rd32('h1FF8); rd32('h2000);
    for (int i = 0; i < 512; i++) begin pix_pat_idx = 9'(i); idle(); end

    // R5: control word, every depth code
    for (int c = 0; c < 8; c++) begin
      wr32('h300, (32'(c) << 20) | ((c & 1) ? 32'h400 : 0) | ((c & 2) ? 32'h800000 : 0));
      rd32('h300);
    end
    wr32('h304, 32'hFFFFFFFF);

    // R6: start offset and cursor position
    wr32('h400, 32'hCAFE0123);
    wr32('h638, 32'hFF3A7C15);
    rd32('h400); rd32('h638);
    wr32('h638, 32'h00FFF000);

    // R7: timing writes and other offsets change nothing
    snap_ctrl = mctrl; snap_top = top_offset; snap_x = cursor_x;
    foreach (bpp_tbl[k]) ;
    wr32('h000, 32'hFFFFFFFF); wr32('h108, 32'hFFFFFFFF); wr32('h110, 32'hFFFFFFFF);
    wr32('h118, 32'hFFFFFFFF); wr32('h150, 32'hFFFFFFFF); wr32('h170, 32'hFFFFFFFF);
    wr32('h200, 32'hFFFFFFFF); wr32('h3000, 32'hFFFFFFFF); wr32('h630, 32'hFFFFFFFF);
    chk(top_offset == snap_top, "R7 top kept", top_offset, snap_top);
    chk(cursor_x == snap_x, "R7 cursor kept", 32'(cursor_x), 32'(snap_x));
    rd32('h300);
    chk(rsp_data == snap_ctrl, "R7 control kept", rsp_data, snap_ctrl);
    // R8: reads of timing and unlisted offsets
    rd32('h000); rd32('h108); rd32('h200); rd32('h3000); rd32('h63C);

    // R9: interrupt set, clear, priority
    cyc(0, 0, 0, 0, 1);
    chk(frame_irq == 1, "R9 set by frame_done", 32'(frame_irq), 1);
    idle(); rd32('h400);
    chk(frame_irq == 1, "R9 read keeps irq", 32'(frame_irq), 1);
    wr32('h108, 32'h1);
    chk(frame_irq == 0, "R9 timing write clears", 32'(frame_irq), 0);
    cyc(1, 1, 'h400, 32'h5, 1);
    chk(frame_irq == 1, "R9 frame_done wins", 32'(frame_irq), 1);
    cyc(1, 0, 'h400, 0, 1);
    wr32('h3000, 32'h0);
    chk(frame_irq == 0, "R9 unlisted write clears", 32'(frame_irq), 0);

    // R10: back-to-back reads and read after write
    wr32('h638, 32'h00123456);
    rd32('h638); rd32('h638); idle();
    chk(rsp_valid == 0, "R10 single response", 32'(rsp_valid), 0);
    repeat (4) idle();

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule